// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block sits between an 8-bit I/O bus and three external counter cores of an interval timer. It decodes the bus address onto three counter access ports and one control port. Two address windows map onto the same four ports. Control words written by the host are split into a target, an access mode, a counting mode and a number format. Ordinary control words are forwarded to the chosen counter core as a one-cycle configuration strobe. The two special forms, the counter latch and the read-back, are acted on inside this block.

For each counter the block keeps a configuration, a write byte pointer and a read byte pointer. It assembles 16-bit load values from one or two byte writes and hands them to the counter core with a one-cycle load strobe. Count and status snapshots are held here until the host has read them out. The counting engines themselves, their gates and their output waveforms live outside this block. This block only samples the count, output state and null-count flag that each core presents.

Top module: `itmr_host_if`

## Requirements
- R1: Reset is synchronous and active low. After reset `bus_rdata` is 00h and no strobe is high. Every counter starts in access mode 11 (low byte then high byte), counting mode 0, binary, with both byte pointers on the low byte.
- R2: The address decoder recognises two windows, 40h–43h and 50h–53h. In either window the low two address bits pick the port: 0, 1 and 2 are counters 0, 1 and 2, and 3 is the control port. Writes to any other address have no effect, and reads from them return FFh.
- R3: In a control word, bits [7:6] give the target: 00, 01 and 10 are counters 0 to 2, and 11 is read-back. Bits [5:4] give the access mode: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. When the target is a counter and the access mode is not 00, the cycle after the write carries `cfg_stb` high for that counter only. In that cycle `cfg_mode` carries bits [3:1] and `cfg_bcd` carries bit 0.
- R4: In low-only mode, a counter-port write gives a load strobe the next cycle with the value {00h, data}. In high-only mode the load value is {data, 00h}.
- R5: In low-then-high mode, the first write to a counter port is held and produces no strobe. The second write produces a load of {second, first}. Successive reads return the low byte and then the high byte.
- R6: A configuring control word for a counter returns both of its byte pointers to the low byte. It also drops any count or status snapshot still held for that counter.
- R7: A latch command (access mode 00) snapshots the counter's 16-bit count and pulses `latch_stb` for that counter the next cycle. Reads then return the snapshot until it has been fully read: one read in single-byte modes, the high-byte read in low-then-high mode. A latch command that arrives while a snapshot is held does nothing.
- R8: A read-back word (target 11) acts on each counter whose select bit is set: bit 1 for counter 0, bit 2 for counter 1, bit 3 for counter 2. Bit 5 low latches the count, as in R7. Bit 4 low latches the status byte {output, null count, access[1:0], mode[2:0], bcd}, with bit 7 being the output. A held status byte is returned by the next read of that counter and does not move the byte pointer.
- R9: A read of the control port returns FFh. It leaves all pointers and snapshots unchanged.
- R10: Read data is registered. It appears on `bus_rdata` the cycle after `bus_rd` and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | I/O address |
| bus_wr | input | 1 | Write request, one cycle per byte |
| bus_rd | input | 1 | Read request, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ct_count | input | 48 | Live 16-bit count from each core, counter i at [16i+15:16i] |
| ct_out | input | 3 | Output state of each core |
| ct_null | input | 3 | Null-count flag of each core |
| cfg_stb | output | 3 | Configuration strobe per counter |
| cfg_mode | output | 9 | Counting mode per counter, counter i at [3i+2:3i] |
| cfg_bcd | output | 3 | BCD select per counter |
| load_stb | output | 3 | Load strobe per counter |
| load_val | output | 48 | Load value per counter, counter i at [16i+15:16i] |
| latch_stb | output | 3 | Count-snapshot strobe per counter |

## Verification
On every cycle, the assertions check the following:
- at most one configuration strobe and at most one load strobe is high;
- every configuration strobe comes from a control-port write;
- every load strobe comes from a counter-port write;
- a latch strobe follows only a control-port write;
- a control-port read returns FFh.

Some behaviour depends on a history of several bus operations, and only the bench scenarios show it. This covers the byte pairing of low-then-high loads and reads, and the snapshot being held across reads while the live count changes. It also covers the second latch being ignored, status being read ahead of the count, and a control word resetting a half-finished byte sequence.

// File: rtl/itmr_pkg.sv
// Package: shared constants for the interval timer host front end.
// Assumes three counters of 16 bits accessed a byte at a time.
package itmr_pkg;
    localparam int NUM_CH    = 3;
    localparam int CNT_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int MODE_W    = 3;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
    localparam logic [7:0] WIN_A     = 8'h40;
    localparam logic [7:0] WIN_B     = 8'h50;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    localparam logic [1:0] TGT_RDBK = 2'b11;
    localparam logic [1:0] CTRL_IDX = 2'b11;
endpackage

// File: rtl/itmr_addr_dec.sv
// Module: itmr_addr_dec
// Maps an 8-bit I/O address onto one of four ports. Two aligned windows of
// four addresses alias each other. Assumes both bases are 4-aligned.
module itmr_addr_dec #(
    parameter logic [7:0] BASE_A = 8'h40,
    parameter logic [7:0] BASE_B = 8'h50
) (
    input  logic [7:0] addr,
    output logic       hit,
    output logic [1:0] port_idx
);
    // Window match on the upper six bits, port index from the lower two.
    always_comb begin
        hit      = (addr[7:2] == BASE_A[7:2]) || (addr[7:2] == BASE_B[7:2]);
        port_idx = addr[1:0];
    end
endmodule

// File: rtl/itmr_chan.sv
// Module: itmr_chan
// One counter's register slice. It holds the access configuration, the write
// and read byte pointers, the low-byte staging register, and the count and
// status snapshots. Assumes at most one of cw_wr, port_wr and port_rd is
// high in any cycle.
module itmr_chan
    import itmr_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_live,
    input  logic              core_out,
    input  logic              core_null,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              cfg_stb,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              cfg_bcd,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic              latch_stb
);
    localparam logic [1:0] MY_TGT = 2'(CH_IDX);

    logic [1:0]        acc_q;
    logic [MODE_W-1:0] mode_q;
    logic              bcd_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic [BYTE_W-1:0] lo_stage_q;
    logic              cnt_held_q;
    logic [CNT_W-1:0]  cnt_snap_q;
    logic              st_held_q;
    logic [BYTE_W-1:0] st_snap_q;

    logic sel_me, rdbk_me, do_cfg, do_latch, do_stat, pick_hi;
    logic [CNT_W-1:0] cnt_src;

    // Decode which control-word actions apply to this counter.
    always_comb begin
        sel_me   = cw_wr && (wdata[7:6] == MY_TGT);
        rdbk_me  = cw_wr && (wdata[7:6] == TGT_RDBK) && wdata[1+CH_IDX];
        do_cfg   = sel_me && (wdata[5:4] != ACC_LATCH);
        do_latch = (sel_me && (wdata[5:4] == ACC_LATCH)) || (rdbk_me && !wdata[5]);
        do_stat  = rdbk_me && !wdata[4];
    end

    // Select the byte a read would return: status first, then the count.
    always_comb begin
        cnt_src = cnt_held_q ? cnt_snap_q : cnt_live;
        pick_hi = (acc_q == ACC_HI) || ((acc_q == ACC_LOHI) && rd_hi_q);
        if (st_held_q)
            rd_byte = st_snap_q;
        else if (pick_hi)
            rd_byte = cnt_src[CNT_W-1 -: BYTE_W];
        else
            rd_byte = cnt_src[BYTE_W-1:0];
    end

    // Configuration, byte sequencing and snapshot state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= ACC_LOHI;
            mode_q     <= '0;
            bcd_q      <= 1'b0;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            lo_stage_q <= '0;
            cnt_held_q <= 1'b0;
            cnt_snap_q <= '0;
            st_held_q  <= 1'b0;
            st_snap_q  <= '0;
        end else begin
            if (do_cfg) begin
                acc_q      <= wdata[5:4];
                mode_q     <= wdata[3:1];
                bcd_q      <= wdata[0];
                wr_hi_q    <= 1'b0;
                rd_hi_q    <= 1'b0;
                cnt_held_q <= 1'b0;
                st_held_q  <= 1'b0;
            end
            if (do_latch && !cnt_held_q) begin
                cnt_held_q <= 1'b1;
                cnt_snap_q <= cnt_live;
            end
            if (do_stat && !st_held_q) begin
                st_held_q <= 1'b1;
                st_snap_q <= {core_out, core_null, acc_q, mode_q, bcd_q};
            end
            if (port_wr && (acc_q == ACC_LOHI)) begin
                if (!wr_hi_q)
                    lo_stage_q <= wdata;
                wr_hi_q <= !wr_hi_q;
            end
            if (port_rd) begin
                if (st_held_q) begin
                    st_held_q <= 1'b0;
                end else begin
                    if (acc_q == ACC_LOHI)
                        rd_hi_q <= !rd_hi_q;
                    if (cnt_held_q && ((acc_q != ACC_LOHI) || rd_hi_q))
                        cnt_held_q <= 1'b0;
                end
            end
        end
    end

    // One-cycle strobes and their payloads toward the counter core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_stb   <= 1'b0;
            load_stb  <= 1'b0;
            load_val  <= '0;
            latch_stb <= 1'b0;
        end else begin
            cfg_stb   <= do_cfg;
            latch_stb <= do_latch && !cnt_held_q;
            load_stb  <= 1'b0;
            if (port_wr) begin
                unique case (acc_q)
                    ACC_LO: begin
                        load_stb <= 1'b1;
                        load_val <= {{(CNT_W-BYTE_W){1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        load_stb <= 1'b1;
                        load_val <= {wdata, {(CNT_W-BYTE_W){1'b0}}};
                    end
                    ACC_LOHI: begin
                        if (wr_hi_q) begin
                            load_stb <= 1'b1;
                            load_val <= {wdata, lo_stage_q};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign cfg_mode = mode_q;
    assign cfg_bcd  = bcd_q;
endmodule

// File: rtl/itmr_host_if.sv
// Module: itmr_host_if
// Top of the interval timer host front end. It decodes the bus, fans control
// words out to three counter slices and registers the read data. Assumes
// bus_wr and bus_rd are never high in the same cycle.
module itmr_host_if
    import itmr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_CH*CNT_W-1:0]  ct_count,
    input  logic [NUM_CH-1:0]     ct_out,
    input  logic [NUM_CH-1:0]     ct_null,
    output logic [NUM_CH-1:0]     cfg_stb,
    output logic [NUM_CH*MODE_W-1:0] cfg_mode,
    output logic [NUM_CH-1:0]     cfg_bcd,
    output logic [NUM_CH-1:0]     load_stb,
    output logic [NUM_CH*CNT_W-1:0]  load_val,
    output logic [NUM_CH-1:0]     latch_stb
);
    logic       hit;
    logic [1:0] idx;
    logic       cw_wr;
    logic [BYTE_W-1:0] ch_byte [NUM_CH];
    logic [BYTE_W-1:0] rd_next;

    itmr_addr_dec #(.BASE_A(WIN_A), .BASE_B(WIN_B)) u_dec (
        .addr(bus_addr), .hit(hit), .port_idx(idx)
    );

    // A write that lands on the control port.
    always_comb cw_wr = bus_wr && hit && (idx == CTRL_IDX);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic on_me;
        always_comb on_me = hit && (idx == 2'(g));
        itmr_chan #(.CH_IDX(g)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .cw_wr(cw_wr),
            .port_wr(bus_wr && on_me),
            .port_rd(bus_rd && on_me),
            .wdata(bus_wdata),
            .cnt_live(ct_count[g*CNT_W +: CNT_W]),
            .core_out(ct_out[g]),
            .core_null(ct_null[g]),
            .rd_byte(ch_byte[g]),
            .cfg_stb(cfg_stb[g]),
            .cfg_mode(cfg_mode[g*MODE_W +: MODE_W]),
            .cfg_bcd(cfg_bcd[g]),
            .load_stb(load_stb[g]),
            .load_val(load_val[g*CNT_W +: CNT_W]),
            .latch_stb(latch_stb[g])
        );
    end

    // Choose the counter byte for a read, idle value elsewhere.
    always_comb begin
        rd_next = IDLE_BYTE;
        for (int i = 0; i < NUM_CH; i++)
            if (hit && (idx == 2'(i)))
                rd_next = ch_byte[i];
    end

    // Register read data on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/itmr_host_if_chk.sv
// Module: itmr_host_if_chk
// Cycle-level properties of the host front end, bound onto the top module.
module itmr_host_if_chk
    import itmr_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic [NUM_CH*CNT_W-1:0]  ct_count,
    input logic [NUM_CH-1:0]     ct_out,
    input logic [NUM_CH-1:0]     ct_null,
    input logic [NUM_CH-1:0]     cfg_stb,
    input logic [NUM_CH*MODE_W-1:0] cfg_mode,
    input logic [NUM_CH-1:0]     cfg_bcd,
    input logic [NUM_CH-1:0]     load_stb,
    input logic [NUM_CH*CNT_W-1:0]  load_val,
    input logic [NUM_CH-1:0]     latch_stb
);
    logic ctrl_addr;
    always_comb ctrl_addr = (bus_addr == (WIN_A | 8'h03)) || (bus_addr == (WIN_B | 8'h03));

    AST_CFG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_stb)); // R3
    AST_CFG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|cfg_stb) |-> $past(rst_n && bus_wr && ctrl_addr)); // R3
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb)); // R4
    AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_stb) |-> $past(rst_n && bus_wr && !ctrl_addr)); // R5
    AST_LATCH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|latch_stb) |-> $past(rst_n && bus_wr && ctrl_addr)); // R7
    AST_CTRL_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && bus_rd && ctrl_addr) |=> (bus_rdata == IDLE_BYTE)); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !bus_rd) |=> $stable(bus_rdata)); // R10
endmodule

bind itmr_host_if itmr_host_if_chk u_chk (.*);

// File: tb/itmr_host_if_bench.sv
module itmr_host_if_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] ct_count = '0;
    logic [2:0]  ct_out = '0;
    logic [2:0]  ct_null = '0;
    logic [2:0]  cfg_stb, cfg_bcd, load_stb, latch_stb;
    logic [8:0]  cfg_mode;
    logic [47:0] load_val;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    itmr_host_if u_itmr_host_if (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Scoreboard monitor: compare each registered read result with the queue.
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", 0, 1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 strobes after reset", {cfg_stb, load_stb, latch_stb}, 9'h0);
        rst_n = 1'b1;
        // R1: counter 2 defaults to low-then-high access
        wr(8'h42, 8'hEF);
        check("R1 no load on first byte", load_stb, 3'b000);
        wr(8'h42, 8'hBE);
        check("R1 load strobe", load_stb, 3'b100);
        check("R1 load value", load_val[47:32], 16'hBEEF);
        // R3: configure counter 0, low-then-high, mode 2, binary
        wr(8'h43, 8'h34);
        check("R3 cfg strobe", cfg_stb, 3'b001);
        check("R3 cfg mode", cfg_mode[2:0], 3'd2);
        check("R3 cfg bcd", cfg_bcd[0], 1'b0);
        // R5: two-byte load
        wr(8'h40, 8'h34);
        check("R5 first byte no load", load_stb, 3'b000);
        wr(8'h40, 8'h12);
        check("R5 load strobe", load_stb, 3'b001);
        check("R5 load value", load_val[15:0], 16'h1234);
        // R2 and R4: counter 1 low only via alias window
        wr(8'h53, 8'h50);
        check("R2 alias cfg strobe", cfg_stb, 3'b010);
        wr(8'h51, 8'hAB);
        check("R4 low-only load", load_val[31:16], 16'h00AB);
        check("R4 low-only strobe", load_stb, 3'b010);
        // R4: counter 2 high only, mode 3, BCD
        wr(8'h43, 8'hA7);
        check("R3 cfg mode ch2", cfg_mode[8:6], 3'd3);
        check("R3 cfg bcd ch2", cfg_bcd[2], 1'b1);
        wr(8'h42, 8'hCD);
        check("R4 high-only load", load_val[47:32], 16'hCD00);
        // R2: unmapped address has no effect
        wr(8'h60, 8'h34);
        check("R2 unmapped write", {cfg_stb, load_stb, latch_stb}, 9'h0);
        rd(8'h61, 8'hFF, "R2 unmapped read");
        // R5: live reads alternate
        ct_count = {16'h9A87, 16'h4321, 16'h5678};
        rd(8'h40, 8'h78, "R5 read low");
        rd(8'h40, 8'h56, "R5 read high");
        rd(8'h41, 8'h21, "R4 low-only read");
        rd(8'h52, 8'h9A, "R4 high-only read");
        // R7: latch, second latch ignored
        wr(8'h43, 8'h00);
        check("R7 latch strobe", latch_stb, 3'b001);
        ct_count[15:0] = 16'h2211;
        wr(8'h43, 8'h00);
        check("R7 second latch ignored", latch_stb, 3'b000);
        rd(8'h40, 8'h78, "R7 held low");
        rd(8'h40, 8'h56, "R7 held high");
        rd(8'h40, 8'h11, "R7 released live low");
        rd(8'h40, 8'h22, "R7 released live high");
        // R9: control port read is idle and harmless
        rd(8'h43, 8'hFF, "R9 control read");
        rd(8'h53, 8'hFF, "R9 alias control read");
        rd(8'h40, 8'h11, "R9 pointer unchanged");
        rd(8'h40, 8'h22, "R9 pointer unchanged high");
        // R8: read-back status and count on counter 1
        ct_out = 3'b010; ct_null = 3'b000;
        wr(8'h43, 8'hC4);
        check("R8 read-back latch strobe", latch_stb, 3'b010);
        ct_count[31:16] = 16'h7766;
        rd(8'h41, 8'h90, "R8 status byte");
        rd(8'h41, 8'h21, "R8 latched count");
        rd(8'h41, 8'h66, "R8 live after release");
        // R8: status only on counter 2
        ct_out = 3'b000; ct_null = 3'b100;
        wr(8'h43, 8'hE8);
        check("R8 status-only no latch strobe", latch_stb, 3'b000);
        rd(8'h42, 8'h67, "R8 status ch2");
        rd(8'h42, 8'h9A, "R8 live high ch2");
        // R6: control word resets write pointer mid-sequence
        wr(8'h40, 8'h01);
        wr(8'h43, 8'h34);
        wr(8'h40, 8'h02);
        check("R6 restart low no load", load_stb, 3'b000);
        wr(8'h40, 8'h03);
        check("R6 restarted load", load_val[15:0], 16'h0302);
        // R6: control word drops a held snapshot and resets read pointer
        rd(8'h40, 8'h11, "R6 read low before");
        wr(8'h43, 8'h00);
        ct_count[15:0] = 16'hBBAA;
        wr(8'h43, 8'h34);
        rd(8'h40, 8'hAA, "R6 snapshot dropped pointer low");
        repeat (2) @(negedge clk);
        check("R10 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule